// File: doc/BRIEF.md
# Cascadable synchronous binary counter

This block is an up-counter made of 4-bit slices that all run on one clock. Each slice can be preset in parallel from a data word and cleared to zero. It counts only when two enable inputs are both high. A slice's carry output rises when the slice holds its all-ones value and its carry-propagate enable is high. That carry feeds the carry-propagate enable of the next slice, so a wide counter needs no extra gating and every bit still changes on the same clock edge.

A parameter sets the number of slices, and the counter width is four times that number. A second parameter chooses how clear acts. In one mode a low clear zeroes the count at once. In the other mode it zeroes the count only at the next rising edge. With the edge-timed clear, a decode of the terminal value can be wired back to the clear input to shorten the count cycle.

Top module: `cnt_chain`

## Requirements
- R1: A low `clr_ni` zeroes the whole count and overrides a low `load_ni` and both enables. The count reads 0 and `carry_o` reads 0 after clear.
- R2: With `ASYNC_CLR=1`, a low `clr_ni` forces `count_o` to 0 without waiting for a clock edge.
- R3: With `ASYNC_CLR=0`, a low `clr_ni` leaves `count_o` unchanged until the next rising edge of `clk_i`, and that edge zeroes it.
- R4: When `clr_ni` is high and `load_ni` is low, a rising edge copies `data_i` into `count_o`, whatever the levels of `en_p_i` and `en_t_i`.
- R5: When `clr_ni` and `load_ni` are high and both `en_p_i` and `en_t_i` are high, each rising edge adds one to `count_o`.
- R6: When `clr_ni` and `load_ni` are high and either enable is low, `count_o` keeps its value across rising edges.
- R7: `carry_o` is high exactly when `en_t_i` is high and every bit of `count_o` is 1. It follows `en_t_i` with no clock edge in between.
- R8: Counting from the all-ones value wraps `count_o` to 0.
- R9: Each slice passes its carry to the next slice within the same edge, so a count of 0x0F in an 8-bit chain steps to 0x10 in one clock.
- R10: With `ASYNC_CLR=0`, driving `clr_ni` low while `count_o` equals 9 makes the counter run through 0 to 9 and repeat (modulus 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| clr_ni | input | 1 | Active-low clear; asynchronous or synchronous, set by `ASYNC_CLR` |
| load_ni | input | 1 | Active-low synchronous parallel preset |
| data_i | input | 4*NUM_SLICES | Preset value |
| en_p_i | input | 1 | Count enable, shared by all slices |
| en_t_i | input | 1 | Count enable that also gates the carry, fed to the first slice |
| count_o | output | 4*NUM_SLICES | Current count |
| carry_o | output | 1 | Carry out of the last slice |

## Verification
The bound checker tests on every clock edge that clear zeroes the count, that load takes the data word, that the count steps by one or holds as the enables decide, that the counter wraps, and that the carry matches its enable and the count. With the asynchronous clear it also checks that the count is zero while clear is low. The bench scenarios cover what an edge-sampled property cannot see. The asynchronous clear acts in the middle of a clock period while the synchronous clear waits for the edge. The carry follows `en_t_i` between edges. A count crosses a slice boundary, and a clear fed back from a decode gives a truncated modulus.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      clr_ni,
  input  logic      load_ni,
  input  logic      en_p_i,
  input  logic      en_t_i,
  output cnt_mode_e mode_o
);
  // fixed priority: clear, then load, then count
  always_comb begin
    if (!clr_ni)                mode_o = MODE_CLEAR;
    else if (!load_ni)          mode_o = MODE_LOAD;
    else if (en_p_i && en_t_i)  mode_o = MODE_COUNT;
    else                        mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
#(
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic               clk_i,
  input  logic               clr_ni,
  input  logic               load_ni,
  input  logic [SLICE_W-1:0] data_i,
  input  logic               en_p_i,
  input  logic               en_t_i,
  output logic [SLICE_W-1:0] q_o,
  output logic               carry_o
);
  cnt_mode_e          mode;
  logic [SLICE_W-1:0] q_q, q_nxt;

  cnt_mode_dec i_dec (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .en_p_i  (en_p_i),
    .en_t_i  (en_t_i),
    .mode_o  (mode)
  );

  always_comb begin
    unique case (mode)
      MODE_CLEAR: q_nxt = '0;
      MODE_LOAD:  q_nxt = data_i;
      MODE_COUNT: q_nxt = q_q + 1'b1;
      default:    q_nxt = q_q;
    endcase
  end

  if (ASYNC_CLR) begin : g_async_clr
    always_ff @(posedge clk_i or negedge clr_ni) begin
      if (!clr_ni) q_q <= '0;
      else         q_q <= q_nxt;
    end
  end else begin : g_sync_clr
    always_ff @(posedge clk_i) begin
      q_q <= q_nxt;
    end
  end

  // carry is combinational in en_t_i so a chain settles within one period
  assign carry_o = en_t_i & (&q_q);
  assign q_o     = q_q;
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 2,
  parameter bit          ASYNC_CLR  = 1'b0,
  localparam int unsigned CNT_W     = NUM_SLICES * SLICE_W
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [CNT_W-1:0] data_i,
  input  logic             en_p_i,
  input  logic             en_t_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_o
);
  logic [NUM_SLICES:0] t_chain;

  assign t_chain[0] = en_t_i;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cnt_slice #(
      .ASYNC_CLR (ASYNC_CLR)
    ) i_slice (
      .clk_i   (clk_i),
      .clr_ni  (clr_ni),
      .load_ni (load_ni),
      .data_i  (data_i[k*SLICE_W +: SLICE_W]),
      .en_p_i  (en_p_i),
      .en_t_i  (t_chain[k]),
      .q_o     (count_o[k*SLICE_W +: SLICE_W]),
      .carry_o (t_chain[k+1])
    );
  end

  assign carry_o = t_chain[NUM_SLICES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk
  import cnt_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 2,
  parameter bit          ASYNC_CLR  = 1'b0,
  localparam int unsigned CNT_W     = NUM_SLICES * SLICE_W
) (
  input logic             clk_i,
  input logic             clr_ni,
  input logic             load_ni,
  input logic [CNT_W-1:0] data_i,
  input logic             en_p_i,
  input logic             en_t_i,
  input logic [CNT_W-1:0] count_o,
  input logic             carry_o
);
  AST_CLEAR_ZERO: assert property (@(posedge clk_i)
    !clr_ni |=> (count_o == '0)); // R1

  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !load_ni |=> (count_o == $past(data_i))); // R4

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && en_p_i && en_t_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && !(en_p_i && en_t_i)) |=> $stable(count_o)); // R6

  AST_CARRY_OUT: assert property (@(posedge clk_i) disable iff (!clr_ni)
    carry_o == (en_t_i && (&count_o))); // R7

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && en_p_i && en_t_i && (&count_o)) |=> (count_o == '0)); // R8

  if (ASYNC_CLR) begin : g_async
    AST_ASYNC_CLEAR: assert property (@(posedge clk_i)
      !clr_ni |-> (count_o == '0)); // R2
  end
endmodule

bind cnt_chain cnt_chain_chk #(
  .NUM_SLICES (NUM_SLICES),
  .ASYNC_CLR  (ASYNC_CLR)
) i_cnt_chain_chk (
  .clk_i   (clk_i),
  .clr_ni  (clr_ni),
  .load_ni (load_ni),
  .data_i  (data_i),
  .en_p_i  (en_p_i),
  .en_t_i  (en_t_i),
  .count_o (count_o),
  .carry_o (carry_o)
);

// File: tb/test_cnt_chain.sv
module test_cnt_chain;
  localparam int unsigned N = 2;
  localparam int unsigned W = 4 * N;

  logic         clk_i = 1'b0;
  logic         clr_ni = 1'b0;
  logic         load_ni = 1'b1;
  logic [W-1:0] data_i = '0;
  logic         en_p_i = 1'b0;
  logic         en_t_i = 1'b0;
  logic [W-1:0] cnt_s, cnt_a;
  logic         cy_s, cy_a;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #10 clk_i = ~clk_i;

  cnt_chain #(.NUM_SLICES(N), .ASYNC_CLR(1'b0)) i_cnt_chain (
    .clk_i (clk_i), .clr_ni (clr_ni), .load_ni (load_ni), .data_i (data_i),
    .en_p_i (en_p_i), .en_t_i (en_t_i), .count_o (cnt_s), .carry_o (cy_s)
  );

  cnt_chain #(.NUM_SLICES(N), .ASYNC_CLR(1'b1)) i_cnt_chain_async (
    .clk_i (clk_i), .clr_ni (clr_ni), .load_ni (load_ni), .data_i (data_i),
    .en_p_i (en_p_i), .en_t_i (en_t_i), .count_o (cnt_a), .carry_o (cy_a)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic preset(input logic [W-1:0] v);
    load_ni = 1'b0; data_i = v;
    step();
    load_ni = 1'b1;
  endtask

  task automatic t_reset();
    clr_ni = 1'b0;
    step(); step();
    chk("R1 reset sync", cnt_s, '0);
    chk("R1 reset async", cnt_a, '0);
    chk("R1 reset carry", W'(cy_s), '0);
    clr_ni = 1'b1;
  endtask

  task automatic t_load();
    en_p_i = 1'b0; en_t_i = 1'b0;
    preset(8'hA5);
    chk("R4 load enables low", cnt_s, 8'hA5);
    en_p_i = 1'b1; en_t_i = 1'b1;
    preset(8'h3C);
    chk("R4 load enables high", cnt_s, 8'h3C);
    chk("R4 load async inst", cnt_a, 8'h3C);
    clr_ni = 1'b0; load_ni = 1'b0; data_i = 8'h77;
    step();
    chk("R1 clear beats load", cnt_s, '0);
    clr_ni = 1'b1; load_ni = 1'b1; en_p_i = 1'b0; en_t_i = 1'b0;
  endtask

  task automatic t_sequence();
    logic [W-1:0] exp;
    preset(8'h0C);
    exp = 8'h0C;
    en_p_i = 1'b1; en_t_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      exp = exp + 1'b1;
      chk((exp == 8'h10) ? "R9 slice carry step" : "R5 count step", cnt_s, exp);
    end
    en_p_i = 1'b0;
    step(); step();
    chk("R6 hold en_p low", cnt_s, 8'h12);
    en_p_i = 1'b1; en_t_i = 1'b0;
    step();
    chk("R6 hold en_t low", cnt_s, 8'h12);
    chk("R6 hold async inst", cnt_a, 8'h12);
    en_p_i = 1'b0;
  endtask

  task automatic t_carry();
    en_p_i = 1'b0; en_t_i = 1'b0;
    preset(8'hFF);
    #1 chk("R7 carry off en_t low", W'(cy_s), '0);
    en_t_i = 1'b1;
    #1 chk("R7 carry follows en_t", W'(cy_s), 1);
    step();
    chk("R6 hold at max", cnt_s, 8'hFF);
    en_p_i = 1'b1;
    step();
    chk("R8 wrap to zero", cnt_s, '0);
    chk("R7 carry after wrap", W'(cy_s), '0);
    en_p_i = 1'b0;
    preset(8'h0F);
    chk("R7 no carry at 0F", W'(cy_s), '0);
    en_p_i = 1'b1;
    step();
    chk("R9 0F to 10", cnt_s, 8'h10);
    en_p_i = 1'b0; en_t_i = 1'b0;
  endtask

  task automatic t_clear_modes();
    preset(8'h5A);
    #5 clr_ni = 1'b0;
    #1;
    chk("R2 async clear immediate", cnt_a, '0);
    chk("R3 sync clear waits", cnt_s, 8'h5A);
    step();
    chk("R3 sync clear at edge", cnt_s, '0);
    clr_ni = 1'b1;
  endtask

  task automatic t_modulus();
    logic [W-1:0] exp;
    clr_ni = 1'b0;
    step();
    clr_ni = 1'b1; en_p_i = 1'b1; en_t_i = 1'b1;
    exp = '0;
    for (int i = 0; i < 25; i++) begin
      chk("R10 modulus ten", cnt_s, exp);
      clr_ni = (cnt_s != 8'd9);
      @(posedge clk_i);
      exp = (exp == 8'd9) ? '0 : exp + 1'b1;
      @(negedge clk_i);
    end
    clr_ni = 1'b1; en_p_i = 1'b0; en_t_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_load();
    t_sequence();
    t_carry();
    t_clear_modes();
    t_modulus();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule